// File: doc/BRIEF.md
# Paged Nonvolatile Byte Array Controller

This block is the byte-level data path of a 512-byte nonvolatile array that sits behind a serial two-wire bus. A serial front end hands it decoded bus events: start and stop conditions, each received byte, and a request whenever the host is about to clock out a read byte. The block decodes the device byte, loads a two-byte array pointer, streams read data, and gathers write data into a 16-byte page buffer. It acknowledges each byte it accepts.

A write is committed to the array only when the bus transfer ends with a stop. The commit then keeps the device busy for a fixed number of clock cycles. During that window the device refuses its own address, so a host can poll until the device answers again. Write bursts stay inside one page: the slot index wraps within the page, and only the slots actually received are changed. Reads run through the whole array and wrap at the top. The storage is modelled as internal registers. The bus electrical layer lives elsewhere.

Top module: `nvm_page_ctl`

## Requirements
- R1: After reset `busy` and `ackOut` are low.
- R2: The device byte is the first byte after a start. Its bits [7:1] are the 7-bit bus address and bit 0 selects the direction (0 = write, 1 = read). It is acknowledged only when bits [7:1] equal 0x57 and the device is not busy. Otherwise `ackOut` stays low and every byte and stop up to the next start is ignored, with no write and no busy window.
- R3: In a write transfer the first byte after the device byte is the high address byte and the second is the low address byte. The array pointer becomes {high[0], low}, and bits [7:1] of the high byte are ignored.
- R4: Every data byte after the two address bytes is acknowledged and held in the page buffer. On a stop, only the slots that were received are written to the array, and all other bytes of that page keep their old contents.
- R5: Each stored data byte advances only the low 4 pointer bits, wrapping from 15 to 0, while pointer bits [8:4] stay fixed. A later byte that lands on a slot already filled replaces it.
- R6: A stop that ends a write with at least one data byte raises `busy` in the cycle after the stop and holds it for exactly WriteCycles cycles. While busy, the device byte is not acknowledged. A stop that ends a write with no data byte does not raise `busy`.
- R7: Each `readStb` in a read transfer presents the byte at the pointer on `rdData` in the next cycle and advances the pointer by one, wrapping from 0x1FF to 0x000.
- R8: A repeated start during the write data phase discards the buffered bytes. Nothing is written and `busy` stays low.
- R9: `ackOut` is a one-cycle pulse in the cycle after the accepted byte's `byteStb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Start or repeated-start condition seen |
| stopStb | input | 1 | Stop condition seen |
| byteStb | input | 1 | A byte from the host is in `rxByte` |
| rxByte | input | 8 | Received byte |
| readStb | input | 1 | Host is about to read the next byte |
| rdData | output | 8 | Read byte, valid the cycle after `readStb` |
| ackOut | output | 1 | Acknowledge pulse for an accepted byte |
| busy | output | 1 | Page commit in progress |

## Verification
The bench pushes a burst past the page end twice: once from mid-page and once with seventeen bytes, so that the wrap and the overwrite of slot zero are both exercised. A design that carried into bit 4 would instead write into the next page. It fills a page, rewrites part of it, and reads it all back, which catches a commit that clears the untouched slots. It reads across 0x1FF, loads a high byte with the spare bits set, and polls the device while a commit is running, which exposes a pointer that runs off the array, spare address bits that are not masked, or an acknowledge given while busy. It also sends bytes to a foreign address, abandons a write with a repeated start and stops after the address only, checking in each case that nothing is committed and `busy` stays low.

// File: rtl/nvm_page_pkg.sv
package nvm_page_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_WDAT,
    S_RDAT
  } ctlStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic storeByte;
    logic readByte;
    logic commit;
  } dpCmdT;

endpackage

// File: rtl/nvm_page_ctrl.sv
module nvm_page_ctrl
  import nvm_page_pkg::*;
#(
  parameter logic [6:0] DevAddr     = 7'h57,
  parameter int         WriteCycles = 4000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startStb,
  input  logic        stopStb,
  input  logic        byteStb,
  input  logic [7:0]  rxByte,
  input  logic        readStb,
  input  logic        anyValid,
  output dpCmdT       cmd,
  output logic        ackOut,
  output logic        busy
);
  localparam int CntW = $clog2(WriteCycles + 1);
  localparam logic [CntW-1:0] CntOne = 1;

  ctlStateT state;
  logic [CntW-1:0] cnt;
  logic plainByte;
  logic devHit;

  assign busy      = (cnt != '0);
  assign plainByte = byteStb && !startStb && !stopStb;
  assign devHit    = (rxByte[7:1] == DevAddr) && !busy;

  always_comb begin
    cmd = '0;
    if (plainByte) begin
      cmd.loadHi    = (state == S_AHI);
      cmd.loadLo    = (state == S_ALO);
      cmd.storeByte = (state == S_WDAT);
    end
    cmd.readByte = readStb && (state == S_RDAT) && !startStb && !stopStb;
    cmd.commit   = stopStb && !startStb && (state == S_WDAT) && anyValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      ackOut <= 1'b0;
      cnt    <= '0;
    end else begin
      ackOut <= 1'b0;
      if (busy) cnt <= cnt - CntOne;
      if (startStb) begin
        state <= S_DEV;
      end else if (stopStb) begin
        state <= S_IDLE;
        if (cmd.commit) cnt <= CntW'(WriteCycles);
      end else if (byteStb) begin
        unique case (state)
          S_DEV: begin
            if (devHit) begin
              ackOut <= 1'b1;
              state  <= rxByte[0] ? S_RDAT : S_AHI;
            end else begin
              state <= S_IDLE;
            end
          end
          S_AHI:  begin ackOut <= 1'b1; state <= S_ALO;  end
          S_ALO:  begin ackOut <= 1'b1; state <= S_WDAT; end
          S_WDAT: ackOut <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R6: the device byte is refused while a commit runs
  a_r6_busy_nack: assert property (@(posedge clk) disable iff (!rstN)
    (busy && plainByte && state == S_DEV) |=> !ackOut);

  // R6: a commit opens the busy window
  a_r6_commit_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |=> busy);

  // R2: a foreign address is never acknowledged
  a_r2_foreign_nack: assert property (@(posedge clk) disable iff (!rstN)
    (plainByte && state == S_DEV && rxByte[7:1] != DevAddr) |=> !ackOut);

  // R9: acknowledge is a single-cycle pulse for a lone byte
  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut && !byteStb) |=> !ackOut);

  // R4: at most one datapath strobe per cycle
  a_r4_one_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmd));

endmodule

// File: rtl/nvm_page_datapath.sv
module nvm_page_datapath
  import nvm_page_pkg::*;
#(
  parameter int AddrW = 9,
  parameter int PageW = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmdT      cmd,
  input  logic [7:0] rxByte,
  output logic [7:0] rdData,
  output logic       anyValid
);
  localparam int Depth     = 1 << AddrW;
  localparam int PageBytes = 1 << PageW;
  localparam logic [AddrW-1:0] AddrOne = 1;
  localparam logic [PageW-1:0] SlotOne = 1;

  logic [7:0]           mem     [Depth];
  logic [7:0]           pageBuf [PageBytes];
  logic [PageBytes-1:0] slotValid;
  logic [AddrW-9:0]     hiKeep;
  logic [AddrW-1:0]     ptr;

  assign anyValid = |slotValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr       <= '0;
      hiKeep    <= '0;
      slotValid <= '0;
      rdData    <= '0;
    end else begin
      if (cmd.loadHi) hiKeep <= rxByte[AddrW-9:0];
      if (cmd.loadLo) begin
        ptr       <= {hiKeep, rxByte};
        slotValid <= '0;
      end
      if (cmd.storeByte) begin
        slotValid[ptr[PageW-1:0]] <= 1'b1;
        ptr <= {ptr[AddrW-1:PageW], ptr[PageW-1:0] + SlotOne};
      end
      if (cmd.readByte) begin
        rdData <= mem[ptr];
        ptr    <= ptr + AddrOne;
      end
      if (cmd.commit) slotValid <= '0;
    end
  end

  // storage: page buffer and array, no reset (contents persist)
  always_ff @(posedge clk) begin
    if (cmd.storeByte) pageBuf[ptr[PageW-1:0]] <= rxByte;
    if (cmd.commit) begin
      for (int i = 0; i < PageBytes; i++) begin
        if (slotValid[i]) mem[{ptr[AddrW-1:PageW], PageW'(i)}] <= pageBuf[i];
      end
    end
  end

  // R5: storing a byte never moves the page
  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rstN)
    cmd.storeByte |=> $stable(ptr[AddrW-1:PageW]));

  // R7: a read steps the pointer by one with wrap
  a_r7_read_step: assert property (@(posedge clk) disable iff (!rstN)
    cmd.readByte |=> (ptr == $past(ptr) + AddrOne));

  // R4: a commit leaves the page buffer empty
  a_r4_commit_clears: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |=> !anyValid);

endmodule

// File: rtl/nvm_page_ctl.sv
module nvm_page_ctl
  import nvm_page_pkg::*;
#(
  parameter logic [6:0] DevAddr     = 7'h57,
  parameter int         WriteCycles = 4000000,
  parameter int         AddrW       = 9,
  parameter int         PageW       = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStb,
  input  logic       stopStb,
  input  logic       byteStb,
  input  logic [7:0] rxByte,
  input  logic       readStb,
  output logic [7:0] rdData,
  output logic       ackOut,
  output logic       busy
);
  dpCmdT cmd;
  logic  anyValid;

  nvm_page_ctrl #(.DevAddr(DevAddr), .WriteCycles(WriteCycles)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .byteStb(byteStb), .rxByte(rxByte), .readStb(readStb),
    .anyValid(anyValid), .cmd(cmd), .ackOut(ackOut), .busy(busy)
  );

  nvm_page_datapath #(.AddrW(AddrW), .PageW(PageW)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rxByte(rxByte),
    .rdData(rdData), .anyValid(anyValid)
  );

endmodule

// File: tb/test_nvm_page_ctl.sv
`timescale 1ns/1ps
module test_nvm_page_ctl;
  localparam int W = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startStb = 1'b0, stopStb = 1'b0, byteStb = 1'b0, readStb = 1'b0;
  logic [7:0] rxByte = '0;
  logic [7:0] rdData;
  logic ackOut, busy;

  int nChecks = 0, nFail = 0, busySeen = 0;
  logic [7:0] model [512];
  logic [7:0] expQ [$];
  logic [7:0] wq [$];
  string curTag = "R7";
  logic sawRead = 1'b0;

  always #2.5 clk = ~clk;

  nvm_page_ctl #(.WriteCycles(W)) i_nvm_page_ctl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .byteStb(byteStb), .rxByte(rxByte), .readStb(readStb),
    .rdData(rdData), .ackOut(ackOut), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishRun;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  // monitor: compare each read result against the scoreboard
  always @(posedge clk) sawRead <= readStb;
  always @(negedge clk) begin
    if (sawRead) begin
      if (expQ.size() == 0) check({curTag, " unexpected read"}, 1, 0);
      else check({curTag, " read data"}, {24'h0, rdData}, {24'h0, expQ.pop_front()});
    end
  end

  task automatic tick;
    @(negedge clk);
    if (busy) busySeen++;
  endtask

  task automatic doStart;
    startStb = 1'b1; tick; startStb = 1'b0;
  endtask

  task automatic doStop;
    stopStb = 1'b1; tick; stopStb = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string tag);
    rxByte = b; byteStb = 1'b1; tick; byteStb = 1'b0;
    check({tag, " ack"}, {31'h0, ackOut}, {31'h0, expAck});
  endtask

  task automatic readOne(input logic [7:0] exp);
    expQ.push_back(exp);
    readStb = 1'b1; tick; readStb = 1'b0;
  endtask

  task automatic waitIdle;
    int guard = 0;
    while (busy && guard < 10 * W) begin tick; guard++; end
  endtask

  // write burst from wq; model follows the in-page wrap rule
  task automatic writeBurst(input logic [15:0] a);
    logic [8:0] p;
    p = a[8:0];
    doStart;
    sendByte(8'hAE, 1'b1, "R2");
    sendByte(a[15:8], 1'b1, "R3");
    sendByte(a[7:0], 1'b1, "R3");
    foreach (wq[i]) begin
      sendByte(wq[i], 1'b1, "R4");
      model[p] = wq[i];
      p = {p[8:4], p[3:0] + 4'd1};
    end
    busySeen = 0;
    doStop;
    check("R6 busy after commit", {31'h0, busy}, 32'h1);
    waitIdle;
    check("R6 busy length", busySeen, W);
  endtask

  task automatic readBurst(input logic [15:0] a, input int n);
    logic [8:0] p;
    p = a[8:0];
    doStart;
    sendByte(8'hAE, 1'b1, "R2");
    sendByte(a[15:8], 1'b1, "R3");
    sendByte(a[7:0], 1'b1, "R3");
    doStart;
    sendByte(8'hAF, 1'b1, "R2");
    for (int i = 0; i < n; i++) begin
      readOne(model[p]);
      p = p + 9'd1;
    end
    tick;
    doStop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 1, 0);
    finishRun;
  end

  initial begin
    repeat (3) tick;
    rstN = 1'b1;
    tick;
    check("R1 busy after reset", {31'h0, busy}, 32'h0);
    check("R1 ack after reset", {31'h0, ackOut}, 32'h0);

    // R4/R6: basic burst, poll during busy
    wq = '{8'hA0, 8'hA1, 8'hA2, 8'hA3};
    doStart;
    sendByte(8'hAE, 1'b1, "R2");
    sendByte(8'h00, 1'b1, "R3");
    sendByte(8'h23, 1'b1, "R3");
    foreach (wq[i]) begin
      sendByte(wq[i], 1'b1, "R4");
      model[9'h023 + 9'(i)] = wq[i];
    end
    busySeen = 0;
    doStop;
    check("R6 busy after stop", {31'h0, busy}, 32'h1);
    doStart;
    sendByte(8'hAE, 1'b0, "R6 poll while busy");
    doStop;
    waitIdle;
    check("R6 busy window length", busySeen, W);
    check("R6 busy clears", {31'h0, busy}, 32'h0);
    doStart;
    sendByte(8'hAE, 1'b1, "R6 poll after busy");
    doStop;
    curTag = "R4";
    readBurst(16'h0023, 4);

    // R4/R5: fill a page, rewrite across its end, read it all
    wq.delete();
    for (int i = 0; i < 16; i++) wq.push_back(8'h10 + 8'(i));
    writeBurst(16'h0030);
    wq = '{8'hC0, 8'hC1, 8'hC2, 8'hC3};
    writeBurst(16'h003E);
    curTag = "R5";
    readBurst(16'h0030, 16);

    // R5: seventeen bytes, slot 0 overwritten by the last one
    wq.delete();
    for (int i = 0; i < 17; i++) wq.push_back(8'h60 + 8'(i));
    writeBurst(16'h0040);
    check("R5 model slot0", {24'h0, model[9'h040]}, 32'h70);
    curTag = "R5";
    readBurst(16'h0040, 16);

    // R3: spare high address bits ignored
    wq = '{8'h77, 8'h78};
    writeBurst(16'hFE10);
    curTag = "R3";
    readBurst(16'h0010, 2);

    // R7: read across the top of the array
    wq = '{8'hE0, 8'hE1};
    writeBurst(16'h01FE);
    wq = '{8'hF0, 8'hF1};
    writeBurst(16'h0000);
    curTag = "R7";
    readBurst(16'h01FE, 4);

    // R2: foreign address, following bytes ignored
    doStart;
    sendByte(8'hA0, 1'b0, "R2 foreign");
    sendByte(8'h00, 1'b0, "R2 ignored");
    sendByte(8'h23, 1'b0, "R2 ignored");
    sendByte(8'h99, 1'b0, "R2 ignored");
    doStop;
    check("R2 no busy", {31'h0, busy}, 32'h0);
    curTag = "R2";
    readBurst(16'h0023, 1);

    // R8: repeated start abandons the page buffer
    doStart;
    sendByte(8'hAE, 1'b1, "R8");
    sendByte(8'h00, 1'b1, "R8");
    sendByte(8'h23, 1'b1, "R8");
    sendByte(8'h5A, 1'b1, "R8");
    doStart;
    sendByte(8'hAF, 1'b1, "R8");
    doStop;
    check("R8 no busy", {31'h0, busy}, 32'h0);
    curTag = "R8";
    readBurst(16'h0023, 1);

    // R6: address-only write does not commit
    doStart;
    sendByte(8'hAE, 1'b1, "R6");
    sendByte(8'h00, 1'b1, "R6");
    sendByte(8'h23, 1'b1, "R6");
    doStop;
    check("R6 address-only no busy", {31'h0, busy}, 32'h0);

    // R9: ack is a single pulse
    tick;
    check("R9 ack pulse ends", {31'h0, ackOut}, 32'h0);

    repeat (3) tick;
    check("R7 scoreboard drained", expQ.size(), 0);
    finishRun;
  end

endmodule